// File: doc/BRIEF.md
# Fixed-Mode Indexed Bank Mapper

This block turns the console CPU and video address buses into upper address lines for a program ROM and a character ROM, and drives a nametable mirroring select. Software picks a bank slot by writing a 3-bit slot number to an even address in the 0x8000–0x9FFF range. It then writes the bank number for that slot to an odd address in the same range. Slots 0 and 1 each cover 2 KiB of video space. Slots 2 to 5 each cover 1 KiB. Slots 6 and 7 each cover an 8 KiB CPU window.

The mode bits that such a select register usually carries are ignored. The layout is frozen in one arrangement:
- The 2 KiB character banks sit low in video space.
- The program window at 0xC000 is switchable.
- The window at 0x8000 is pinned to the second-to-last program bank.
- The top window is pinned to the last program bank.

A mirroring register at even addresses of 0xA000–0xBFFF selects vertical or horizontal mirroring.

Top module: `fixmode_bank_mapper`

## Requirements
- R1: After reset, all eight bank slots hold 0, the selected slot is 0 and `mirror_h` is 0 (vertical).
- R2: A write with A15=1, A14:13=00 and A0=0 stores data bits 2:0 as the selected slot. A write with A15=1, A14:13=00 and A0=1 loads the full data byte into the selected slot. Data bits 7:3 of a select write, including bits 7 and 6, have no effect on any mapping.
- R3: CPU addresses 0x8000–0x9FFF always map to program bank 2^PRG_BANK_W−2.
- R4: CPU addresses 0xE000–0xFFFF always map to program bank 2^PRG_BANK_W−1.
- R5: A write with A15=1, A14:13=01 and A0=0 sets `mirror_h` to data bit 0 (0 = vertical, 1 = horizontal). No other write changes `mirror_h`. The new value shows from the cycle after the write edge.
- R6: CPU window 0xC000–0xDFFF uses slot 6 and window 0xA000–0xBFFF uses slot 7. Each uses the low PRG_BANK_W bits of the slot.
- R7: Video addresses 0x0000–0x07FF use slot 0 and 0x0800–0x0FFF use slot 1. In both cases the slot's bit 0 is replaced by video address bit 10, so the result is a 1 KiB bank number.
- R8: Video addresses 0x1000–0x1FFF use slots 2, 3, 4 and 5 in order of video address bits 11:10.
- R9: Writes with A15=0, writes with A14:13 equal to 10 or 11, and odd writes to 0xA000–0xBFFF change no slot, no selection and no mirroring.
- R10: `prg_rom_addr[12:0]` equals CPU address bits 12:0, and `chr_rom_addr[9:0]` equals video address bits 9:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| ppu_addr | input | 13 | Video address within pattern space |
| prg_rom_addr | output | PRG_BANK_W+13 | Program ROM address |
| chr_rom_addr | output | CHR_BANK_W+10 | Character ROM address |
| mirror_h | output | 1 | 1 = horizontal, 0 = vertical mirroring |

## Verification
Each slot is loaded with a distinct byte, and the select writes carry bits 7 and 6 set. A design that honoured the mode bits would therefore move the 2 KiB banks to the upper half or swap the 0x8000 and 0xC000 windows, and the bench would see it. The video probes sweep all eight 1 KiB regions with both levels of address bit 10. This separates the low-bit substitution of the 2 KiB slots from the plain 1 KiB slots. Stray writes are then sent below 0x8000, to the upper windows and to odd 0xA000 addresses. A final sweep shows that none of them landed in a slot or in the mirroring bit.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        WIN_LOW  = 2'b00,
        WIN_A000 = 2'b01,
        WIN_C000 = 2'b10,
        WIN_TOP  = 2'b11
    } cpu_win_e;

    localparam logic [SLOT_IDX_W-1:0] SLOT_2K_BASE = 3'd0;
    localparam logic [SLOT_IDX_W-1:0] SLOT_1K_BASE = 3'd2;
    localparam logic [SLOT_IDX_W-1:0] SLOT_PRG_C = 3'd6;
    localparam logic [SLOT_IDX_W-1:0] SLOT_PRG_A = 3'd7;
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
    import mapper_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cpu_wr,
    input  logic [15:0]                         cpu_addr,
    input  logic [DATA_W-1:0]                   cpu_data,
    output logic [SLOT_IDX_W-1:0]               sel_q,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]    bank_q,
    output logic                                mirror_q
);
    typedef struct packed {
        logic [SLOT_IDX_W-1:0]            sel;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] bank;
        logic                             mir;
    } regs_t;

    regs_t st_d, st_q;
    cpu_win_e win;

    always_comb begin
        win  = cpu_win_e'(cpu_addr[14:13]);
        st_d = st_q;
        if (cpu_wr && cpu_addr[15]) begin
            unique case ({win, cpu_addr[0]})
                {WIN_LOW, 1'b0}:  st_d.sel = cpu_data[SLOT_IDX_W-1:0];
                {WIN_LOW, 1'b1}:  st_d.bank[st_q.sel] = cpu_data;
                {WIN_A000, 1'b0}: st_d.mir = cpu_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q    = st_q.sel;
    assign bank_q   = st_q.bank;
    assign mirror_q = st_q.mir;
endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6
) (
    input  logic [15:0]                      cpu_addr,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q,
    output logic [PRG_BANK_W+12:0]           prg_rom_addr
);
    localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;
    localparam logic [PRG_BANK_W-1:0] PENULT_BANK = LAST_BANK - 1'b1;

    logic [PRG_BANK_W-1:0] bank_d;

    always_comb begin
        unique case (cpu_win_e'(cpu_addr[14:13]))
            WIN_LOW:  bank_d = PENULT_BANK;
            WIN_A000: bank_d = bank_q[SLOT_PRG_A][PRG_BANK_W-1:0];
            WIN_C000: bank_d = bank_q[SLOT_PRG_C][PRG_BANK_W-1:0];
            default:  bank_d = LAST_BANK;
        endcase
    end

    assign prg_rom_addr = {bank_d, cpu_addr[12:0]};
endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
#(
    parameter int CHR_BANK_W = 8
) (
    input  logic [12:0]                      ppu_addr,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q,
    output logic [CHR_BANK_W+9:0]            chr_rom_addr
);
    localparam int NUM_1K = 4;
    localparam int NUM_2K = 2;

    logic [NUM_1K-1:0][CHR_BANK_W-1:0] small_bank;
    logic [NUM_2K-1:0][CHR_BANK_W-1:0] big_bank;
    logic [CHR_BANK_W-1:0] bank_d;

    for (genvar g = 0; g < NUM_1K; g++) begin : g_small
        assign small_bank[g] = bank_q[int'(SLOT_1K_BASE) + g][CHR_BANK_W-1:0];
    end

    for (genvar g = 0; g < NUM_2K; g++) begin : g_big
        assign big_bank[g] = {bank_q[int'(SLOT_2K_BASE) + g][CHR_BANK_W-1:1], 1'b0};
    end

    always_comb begin
        if (ppu_addr[12]) bank_d = small_bank[ppu_addr[11:10]];
        else              bank_d = big_bank[ppu_addr[11]] | {{(CHR_BANK_W-1){1'b0}}, ppu_addr[10]};
    end

    assign chr_rom_addr = {bank_d, ppu_addr[9:0]};
endmodule

// File: rtl/fixmode_bank_mapper.sv
module fixmode_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               cpu_data,
    input  logic                     cpu_wr,
    input  logic [12:0]              ppu_addr,
    output logic [PRG_BANK_W+12:0]   prg_rom_addr,
    output logic [CHR_BANK_W+9:0]    chr_rom_addr,
    output logic                     mirror_h
);
    logic [SLOT_IDX_W-1:0]            sel_q;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q;

    mapper_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .sel_q    (sel_q),
        .bank_q   (bank_q),
        .mirror_q (mirror_h)
    );

    mapper_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
        .cpu_addr     (cpu_addr),
        .bank_q       (bank_q),
        .prg_rom_addr (prg_rom_addr)
    );

    mapper_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
        .ppu_addr     (ppu_addr),
        .bank_q       (bank_q),
        .chr_rom_addr (chr_rom_addr)
    );
endmodule

// File: rtl/fixmode_bank_mapper_chk.sv
module fixmode_bank_mapper_chk
    import mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 6,
    parameter int CHR_BANK_W = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [15:0]                      cpu_addr,
    input logic [7:0]                       cpu_data,
    input logic                             cpu_wr,
    input logic [12:0]                      ppu_addr,
    input logic [PRG_BANK_W+12:0]           prg_rom_addr,
    input logic [CHR_BANK_W+9:0]            chr_rom_addr,
    input logic                             mirror_h,
    input logic [SLOT_IDX_W-1:0]            sel_q,
    input logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q
);
    localparam logic [PRG_BANK_W-1:0] TOP_BANK = '1;
    localparam logic [PRG_BANK_W-1:0] NEXT_BANK = TOP_BANK - 1'b1;

    logic mir_wr;
    logic bank_wr;
    assign mir_wr  = cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0];
    assign bank_wr = cpu_wr && cpu_addr[15:13] == 3'b100;

    AST_LOW_WIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:13] == 3'b100 |-> prg_rom_addr[PRG_BANK_W+12:13] == NEXT_BANK); // R3

    AST_TOP_WIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15:13] == 3'b111 |-> prg_rom_addr[PRG_BANK_W+12:13] == TOP_BANK); // R4

    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mir_wr |=> mirror_h == $past(cpu_data[0])); // R5

    AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mir_wr |=> $stable(mirror_h)); // R5

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_q) && $stable(sel_q)); // R9

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rom_addr[12:0] == cpu_addr[12:0] && chr_rom_addr[9:0] == ppu_addr[9:0]); // R10
endmodule

bind fixmode_bank_mapper fixmode_bank_mapper_chk #(
    .PRG_BANK_W(PRG_BANK_W),
    .CHR_BANK_W(CHR_BANK_W)
) chk_i (.*);

// File: tb/fixmode_bank_mapper_tb_top.sv
module fixmode_bank_mapper_tb_top;
    localparam int PW = 6;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0] cpu_data = '0;
    logic cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [PW+12:0] prg_rom_addr;
    logic [CW+9:0] chr_rom_addr;
    logic mirror_h;

    always #10 clk = ~clk;

    fixmode_bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) dut_i (.*);

    typedef struct {
        string          tag;
        logic [PW+12:0] prg;
        logic [CW+9:0]  chr;
        logic           mir;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_bank [8];
    logic [2:0] m_sel;
    logic       m_mir;

    function automatic logic [PW+12:0] exp_prg(logic [15:0] a);
        logic [PW-1:0] b;
        case (a[14:13])
            2'b00:   b = PW'(2**PW - 2);
            2'b01:   b = m_bank[7][PW-1:0];
            2'b10:   b = m_bank[6][PW-1:0];
            default: b = PW'(2**PW - 1);
        endcase
        return {b, a[12:0]};
    endfunction

    function automatic logic [CW+9:0] exp_chr(logic [12:0] p);
        logic [CW-1:0] b;
        if (p[12]) b = m_bank[2 + int'(p[11:10])][CW-1:0];
        else       b = {m_bank[int'(p[11])][CW-1:1], p[10]};
        return {b, p[9:0]};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        if (a[15] && a[14:13] == 2'b00 && !a[0]) m_sel = d[2:0];
        else if (a[15] && a[14:13] == 2'b00)     m_bank[m_sel] = d;
        else if (a[15] && a[14:13] == 2'b01 && !a[0]) m_mir = d[0];
    endtask

    task automatic probe(input string tag, input logic [15:0] a, input logic [12:0] p);
        item_t it;
        @(posedge clk); #1;
        cpu_addr = a; ppu_addr = p;
        it.tag = tag; it.prg = exp_prg(a); it.chr = exp_chr(p); it.mir = m_mir;
        sb_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (prg_rom_addr !== it.prg || chr_rom_addr !== it.chr || mirror_h !== it.mir) begin
                errors++;
                $display("FAIL %s: prg=%h chr=%h mir=%b expected prg=%h chr=%h mir=%b",
                         it.tag, prg_rom_addr, chr_rom_addr, mirror_h, it.prg, it.chr, it.mir);
            end
        end
    end

    task automatic sweep(input string tag);
        for (int w = 0; w < 4; w++)
            probe(tag, 16'h8000 + 16'(w) * 16'h2000 + 16'h0155, 13'(w * 16'h0800 + 16'h0123));
        for (int r = 0; r < 8; r++)
            probe(tag, 16'hC000 + 16'(r), 13'(r * 16'h0400 + 16'h00AB));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_bank[i] = '0;
        m_sel = '0; m_mir = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset contents, R10 offsets carried through
        sweep("R1_reset");
        probe("R10_offsets", 16'hDFFF, 13'h13FF);
        // R2: select writes carry bits 7:6 set, which must not alter the layout
        for (int i = 0; i < 8; i++) begin
            wr(16'h8000 + 16'(2 * i), 8'hC0 | 8'(i));
            wr(16'h8001, 8'h35 + 8'(i * 8'h1B));
        end
        sweep("R2_load");
        probe("R3_low_fixed", 16'h9ABC, 13'h0000);
        probe("R4_top_fixed", 16'hFFFF, 13'h1FFF);
        probe("R6_win_c000", 16'hC777, 13'h0400);
        probe("R6_win_a000", 16'hA123, 13'h0C00);
        probe("R7_2k_lsb", 16'h8000, 13'h0400);
        probe("R8_1k_slots", 16'h8000, 13'h1C00);
        // R5: mirroring register
        wr(16'hA000, 8'hFF);
        probe("R5_mirror_h", 16'hA000, 13'h0000);
        wr(16'hA000, 8'hFE);
        probe("R5_mirror_v", 16'hA000, 13'h0000);
        wr(16'hBFFE, 8'h01);
        probe("R5_mirror_alias", 16'hA000, 13'h0000);
        // R9: stray writes leave slots, selection and mirroring untouched
        wr(16'h8000, 8'h03);
        wr(16'h0000, 8'h05);
        wr(16'h0001, 8'h99);
        wr(16'h7FFF, 8'h77);
        wr(16'hC000, 8'h04);
        wr(16'hC001, 8'hEE);
        wr(16'hE001, 8'hDD);
        wr(16'hA001, 8'h00);
        sweep("R9_stray");
        wr(16'h8001, 8'h5A);
        sweep("R9_sel_kept");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule